// File: doc/BRIEF.md
# Capture Reload Up-Down Timer

A 16-bit timer/counter paired with a 16-bit capture/reload register. It has five operating modes. In capture mode it free-runs and latches its count on an external event. In reload mode it counts up and restarts from the reload value. In up/down mode an external level picks the count direction. In baud mode it makes an overflow pulse stream for a serial port. In clock-output mode it drives a square wave. The count advances once per machine cycle as a timer. As a counter it advances on falling edges of an external count pin. The baud and clock-output modes use a fast rate of one step every two oscillator clocks.

The block runs on the oscillator clock and derives the machine-cycle and fast strobes itself. Software talks to it through strobes. These load the count or the reload register and clear the two sticky flags: the overflow flag and the event flag. Each of the two external pins passes through a two-stage synchronizer before its falling edge is detected. The serial port that uses the overflow pulses and the register bus decoding sit outside the block.

Top module: `capture_reload_timer`

## Requirements
- R1: While reset is asserted, count and capture register read 0, and the overflow flag, event flag, interrupt, overflow pulse and clock output are all 0.
- R2: In capture, reload and up/down modes with cnt_sel_i=0, the count advances once every MC_DIV (12) clocks. With cnt_sel_i=1, it advances once for each falling edge of cnt_pin_i after two-stage synchronization.
- R3: The first clock with run_i high only starts the timer, even when a step strobe falls on it. While run_i is low the count holds.
- R4: Capture mode: a step at 0xFFFF wraps the count to 0x0000 and sets the overflow flag. A synchronized falling edge of evt_pin_i with evt_en_i=1 copies the count into the capture register and sets the event flag. With evt_en_i=0 such an edge changes neither.
- R5: Reload mode: a step at 0xFFFF loads the count from the capture register and sets the overflow flag.
- R6: Up/down mode: synchronized evt_pin_i high counts up, and a step at 0xFFFF loads the capture value. Low counts down, and a step while the count equals the capture value loads 0xFFFF. Each such wrap sets the overflow flag and inverts the event flag.
- R7: Baud mode: a step at 0xFFFF loads the capture value and raises baud_pulse_o for one clock, while the overflow flag stays untouched. An evt_pin_i falling edge with evt_en_i=1 sets the event flag.
- R8: Clock-output mode: each step at 0xFFFF loads the capture value and inverts clk_out_o, while the overflow flag stays untouched. clk_out_o changes in no other mode.
- R9: In baud mode with cnt_sel_i=0, and in clock-output mode, the count advances once every FAST_DIV (2) clocks.
- R10: irq_o is the overflow flag ORed with the event flag, except in up/down mode, where the event flag is left out.
- R11: Both flags stay set until their clear strobe. A set and a clear in the same clock leave the flag set.
- R12: Mode priority, highest first: clkout_en_i, baud_en_i, cap_mode_i, updown_i, otherwise reload.
- R13: wr_cnt_i loads wr_data_i into the count and wins over a step. wr_cap_i loads the capture register, but a capture event in the same clock wins over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Run enable |
| cnt_sel_i | input | 1 | 1 = count external pin edges, 0 = internal timing |
| cap_mode_i | input | 1 | Capture mode select |
| updown_i | input | 1 | Up/down reload select |
| baud_en_i | input | 1 | Baud generator mode |
| clkout_en_i | input | 1 | Clock-output mode |
| evt_en_i | input | 1 | Enables evt_pin_i falling-edge events |
| cnt_pin_i | input | 1 | External count pin (asynchronous) |
| evt_pin_i | input | 1 | External event / direction pin (asynchronous) |
| clr_ovf_i | input | 1 | Clears the overflow flag |
| clr_evt_i | input | 1 | Clears the event flag |
| wr_cnt_i | input | 1 | Loads wr_data_i into the count |
| wr_cap_i | input | 1 | Loads wr_data_i into the capture register |
| wr_data_i | input | 16 | Write data |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| evt_flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request |
| baud_pulse_o | output | 1 | One-clock overflow pulse in baud mode |
| clk_out_o | output | 1 | Clock-output pin value |
| count_o | output | 16 | Current count |
| capture_o | output | 16 | Capture/reload register |

## Verification
The properties assume that the mode inputs seen on one clock also chose the mode that shaped the result on the next. The checks on first-cycle idling and on holding while stopped also assume that run_i and wr_cnt_i are the only things that can move the count. The stimulus changes mode inputs only on falling clock edges, away from any edge it measures. It holds each external pin level for at least three clocks so that the synchronizer sees every edge. It also stops and restarts the timer at phases it picks on purpose, including a restart on a machine-cycle strobe.

// File: rtl/crt_pkg.sv
`timescale 1ns/1ps
package crt_pkg;

    typedef enum logic [2:0] {
        MODE_RELOAD  = 3'd0,
        MODE_UPDOWN  = 3'd1,
        MODE_CAPTURE = 3'd2,
        MODE_BAUD    = 3'd3,
        MODE_CLKOUT  = 3'd4
    } crt_mode_e;

    // Resolve the mode select inputs in fixed priority order.
    function automatic crt_mode_e crt_pick_mode(input logic clkout, input logic baud,
                                                input logic cap, input logic updown);
        if (clkout)      return MODE_CLKOUT;
        else if (baud)   return MODE_BAUD;
        else if (cap)    return MODE_CAPTURE;
        else if (updown) return MODE_UPDOWN;
        else             return MODE_RELOAD;
    endfunction

endpackage

// File: rtl/crt_prescaler.sv
`timescale 1ns/1ps
module crt_prescaler #(
    parameter int MC_DIV   = 12,
    parameter int FAST_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic mc_tick_o,
    output logic fast_tick_o
);
    localparam int MCW = (MC_DIV > 1) ? $clog2(MC_DIV) : 1;
    localparam int FW  = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
    localparam logic [MCW-1:0] MC_LAST = MCW'(MC_DIV - 1);
    localparam logic [FW-1:0]  F_LAST  = FW'(FAST_DIV - 1);

    logic [MCW-1:0] mc_d, mc_q;
    logic [FW-1:0]  f_d, f_q;

    always_comb begin
        mc_d = (mc_q == MC_LAST) ? '0 : mc_q + 1'b1;
        f_d  = (f_q == F_LAST) ? '0 : f_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_q <= '0;
            f_q  <= '0;
        end else begin
            mc_q <= mc_d;
            f_q  <= f_d;
        end
    end

    assign mc_tick_o   = (mc_q == MC_LAST);
    assign fast_tick_o = (f_q == F_LAST);
endmodule

// File: rtl/crt_sync.sv
`timescale 1ns/1ps
module crt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = pin_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], pin_i};
        end
    endgenerate

    // Pins idle high, so the chain resets to ones.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/capture_reload_timer.sv
`timescale 1ns/1ps
module capture_reload_timer #(
    parameter int W           = 16,
    parameter int MC_DIV      = 12,
    parameter int FAST_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         cnt_sel_i,
    input  logic         cap_mode_i,
    input  logic         updown_i,
    input  logic         baud_en_i,
    input  logic         clkout_en_i,
    input  logic         evt_en_i,
    input  logic         cnt_pin_i,
    input  logic         evt_pin_i,
    input  logic         clr_ovf_i,
    input  logic         clr_evt_i,
    input  logic         wr_cnt_i,
    input  logic         wr_cap_i,
    input  logic [W-1:0] wr_data_i,
    output logic         ovf_flag_o,
    output logic         evt_flag_o,
    output logic         irq_o,
    output logic         baud_pulse_o,
    output logic         clk_out_o,
    output logic [W-1:0] count_o,
    output logic [W-1:0] capture_o
);
    import crt_pkg::*;

    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cap;
        logic         ovf;
        logic         evt;
        logic         clk_out;
        logic         pulse;
        logic         started;
        logic         cnt_prev;
        logic         evt_prev;
    } crt_state_t;

    crt_state_t s_d, s_q;

    logic      mc_tick, fast_tick;
    logic      cnt_lvl, evt_lvl;
    logic      cnt_fall, evt_fall;
    logic      active, step, at_top, wrap_hit, grab, evt_base;
    crt_mode_e mode;

    crt_prescaler #(.MC_DIV(MC_DIV), .FAST_DIV(FAST_DIV)) i_presc (
        .clk         (clk),
        .rst_n       (rst_n),
        .mc_tick_o   (mc_tick),
        .fast_tick_o (fast_tick)
    );

    crt_sync #(.STAGES(SYNC_STAGES)) i_sync_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (cnt_pin_i),
        .level_o (cnt_lvl)
    );

    crt_sync #(.STAGES(SYNC_STAGES)) i_sync_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (evt_pin_i),
        .level_o (evt_lvl)
    );

    assign mode = crt_pick_mode(clkout_en_i, baud_en_i, cap_mode_i, updown_i);

    always_comb begin
        s_d         = s_q;
        s_d.started = run_i;
        s_d.pulse   = 1'b0;
        s_d.cnt_prev = cnt_lvl;
        s_d.evt_prev = evt_lvl;

        cnt_fall = s_q.cnt_prev & ~cnt_lvl;
        evt_fall = s_q.evt_prev & ~evt_lvl;
        active   = run_i & s_q.started;
        at_top   = (s_q.cnt == TOP);
        wrap_hit = 1'b0;

        unique case (mode)
            MODE_CLKOUT: step = fast_tick;
            MODE_BAUD:   step = cnt_sel_i ? cnt_fall : fast_tick;
            default:     step = cnt_sel_i ? cnt_fall : mc_tick;
        endcase

        // Clears first, so that a same-cycle set wins.
        s_d.ovf  = s_q.ovf & ~clr_ovf_i;
        evt_base = s_q.evt & ~clr_evt_i;
        s_d.evt  = evt_base;

        if (active && step) begin
            unique case (mode)
                MODE_CAPTURE: begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (at_top) s_d.ovf = 1'b1;
                end
                MODE_RELOAD: begin
                    if (at_top) begin
                        s_d.cnt = s_q.cap;
                        s_d.ovf = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                MODE_UPDOWN: begin
                    if (evt_lvl) begin
                        if (at_top) begin
                            s_d.cnt  = s_q.cap;
                            wrap_hit = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end else begin
                        if (s_q.cnt == s_q.cap) begin
                            s_d.cnt  = TOP;
                            wrap_hit = 1'b1;
                        end else begin
                            s_d.cnt = s_q.cnt - 1'b1;
                        end
                    end
                    if (wrap_hit) begin
                        s_d.ovf = 1'b1;
                        s_d.evt = ~evt_base;
                    end
                end
                MODE_BAUD: begin
                    if (at_top) begin
                        s_d.cnt   = s_q.cap;
                        s_d.pulse = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                MODE_CLKOUT: begin
                    if (at_top) begin
                        s_d.cnt     = s_q.cap;
                        s_d.clk_out = ~s_q.clk_out;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end

        grab = active & evt_fall & evt_en_i &
               ((mode == MODE_CAPTURE) | (mode == MODE_BAUD) | (mode == MODE_CLKOUT));
        if (grab) s_d.evt = 1'b1;

        if (grab && (mode == MODE_CAPTURE)) s_d.cap = s_q.cnt;
        else if (wr_cap_i)                  s_d.cap = wr_data_i;

        if (wr_cnt_i) s_d.cnt = wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.cnt_prev <= 1'b1;
            s_q.evt_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ovf_flag_o   = s_q.ovf;
    assign evt_flag_o   = s_q.evt;
    assign irq_o        = s_q.ovf | (s_q.evt & (mode != MODE_UPDOWN));
    assign baud_pulse_o = s_q.pulse;
    assign clk_out_o    = s_q.clk_out;
    assign count_o      = s_q.cnt;
    assign capture_o    = s_q.cap;
endmodule

// File: rtl/capture_reload_timer_chk.sv
`timescale 1ns/1ps
module capture_reload_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run_i,
    input logic         cap_mode_i,
    input logic         baud_en_i,
    input logic         clkout_en_i,
    input logic         evt_en_i,
    input logic         wr_cnt_i,
    input logic         wr_cap_i,
    input logic         ovf_flag_o,
    input logic         baud_pulse_o,
    input logic         clk_out_o,
    input logic [W-1:0] count_o,
    input logic [W-1:0] capture_o
);
    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run_i) && !$past(wr_cnt_i)) |-> $stable(count_o)); // R3

    AST_FIRST_CYCLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_i) && !$past(run_i, 2) && !$past(wr_cnt_i)) |-> $stable(count_o)); // R3

    AST_CAPTURE_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(capture_o) |-> ($past(wr_cap_i) ||
            $past(evt_en_i && cap_mode_i && !baud_en_i && !clkout_en_i))); // R4

    AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag_o) |-> !$past(baud_en_i)); // R7

    AST_CLKOUT_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag_o) |-> !$past(clkout_en_i)); // R8

    AST_CLK_ONLY_CLKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_out_o) |-> $past(clkout_en_i)); // R8

    AST_PULSE_ONLY_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
        baud_pulse_o |-> $past(baud_en_i && !clkout_en_i)); // R12
endmodule

bind capture_reload_timer capture_reload_timer_chk #(.W(W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run_i),
    .cap_mode_i   (cap_mode_i),
    .baud_en_i    (baud_en_i),
    .clkout_en_i  (clkout_en_i),
    .evt_en_i     (evt_en_i),
    .wr_cnt_i     (wr_cnt_i),
    .wr_cap_i     (wr_cap_i),
    .ovf_flag_o   (ovf_flag_o),
    .baud_pulse_o (baud_pulse_o),
    .clk_out_o    (clk_out_o),
    .count_o      (count_o),
    .capture_o    (capture_o)
);

// File: tb/test_capture_reload_timer.sv
`timescale 1ns/1ps
module test_capture_reload_timer;
    localparam int MC = 12;
    localparam int FD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_i = 0, cnt_sel_i = 0, cap_mode_i = 0, updown_i = 0, baud_en_i = 0;
    logic clkout_en_i = 0, evt_en_i = 0, cnt_pin_i = 1, evt_pin_i = 1;
    logic clr_ovf_i = 0, clr_evt_i = 0, wr_cnt_i = 0, wr_cap_i = 0;
    logic [15:0] wr_data_i = '0;
    logic ovf_flag_o, evt_flag_o, irq_o, baud_pulse_o, clk_out_o;
    logic [15:0] count_o, capture_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    capture_reload_timer i_capture_reload_timer (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .cnt_sel_i(cnt_sel_i),
        .cap_mode_i(cap_mode_i), .updown_i(updown_i), .baud_en_i(baud_en_i),
        .clkout_en_i(clkout_en_i), .evt_en_i(evt_en_i), .cnt_pin_i(cnt_pin_i),
        .evt_pin_i(evt_pin_i), .clr_ovf_i(clr_ovf_i), .clr_evt_i(clr_evt_i),
        .wr_cnt_i(wr_cnt_i), .wr_cap_i(wr_cap_i), .wr_data_i(wr_data_i),
        .ovf_flag_o(ovf_flag_o), .evt_flag_o(evt_flag_o), .irq_o(irq_o),
        .baud_pulse_o(baud_pulse_o), .clk_out_o(clk_out_o),
        .count_o(count_o), .capture_o(capture_o)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_mc, m_fd, m_cnt, m_cap, md, nc, ncap;
    bit m_tf, m_ev, m_clk, m_bp, m_started;
    bit ntf, nev, nclk, nbp;
    bit [1:0] m_cs, m_es;      // synchronizer stages, [1] is the synced level
    bit m_cprev, m_eprev;
    bit mct, fst, cf, ef, stp, act, grab;

    function automatic int mode_now();
        if (clkout_en_i) return 4;
        if (baud_en_i)   return 3;
        if (cap_mode_i)  return 2;
        if (updown_i)    return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_mc = 0; m_fd = 0; m_cnt = 0; m_cap = 0;
            m_tf = 0; m_ev = 0; m_clk = 0; m_bp = 0; m_started = 0;
            m_cs = 2'b11; m_es = 2'b11; m_cprev = 1; m_eprev = 1;
        end else begin
            md  = mode_now();
            mct = (m_mc == MC - 1);
            fst = (m_fd == FD - 1);
            cf  = m_cprev && !m_cs[1];
            ef  = m_eprev && !m_es[1];
            if (md == 4)      stp = fst;
            else if (md == 3) stp = cnt_sel_i ? cf : fst;
            else              stp = cnt_sel_i ? cf : mct;
            act = run_i && m_started;
            nc = m_cnt; ncap = m_cap;
            ntf = m_tf && !clr_ovf_i; nev = m_ev && !clr_evt_i;
            nclk = m_clk; nbp = 0;
            if (act && stp) begin
                if (md == 1 && !m_es[1]) begin
                    if (m_cnt == m_cap) begin nc = 65535; ntf = 1; nev = !nev; end
                    else nc = m_cnt - 1;
                end else begin
                    nc = m_cnt + 1;
                    if (nc > 65535) begin
                        if (md == 2) nc = 0; else nc = m_cap;
                        if (md <= 2) ntf = 1;
                        if (md == 1) nev = !nev;
                        if (md == 3) nbp = 1;
                        if (md == 4) nclk = !nclk;
                    end
                end
            end
            grab = act && ef && evt_en_i && (md >= 2);
            if (grab) nev = 1;
            if (grab && md == 2) ncap = m_cnt;
            else if (wr_cap_i)   ncap = wr_data_i;
            if (wr_cnt_i) nc = wr_data_i;
            m_cnt = nc; m_cap = ncap; m_tf = ntf; m_ev = nev; m_clk = nclk; m_bp = nbp;
            m_started = run_i;
            m_cprev = m_cs[1]; m_eprev = m_es[1];
            m_cs = {m_cs[0], cnt_pin_i};
            m_es = {m_es[0], evt_pin_i};
            m_mc = (m_mc + 1) % MC;
            m_fd = (m_fd + 1) % FD;
        end
        #1;
        if (rst_n && !done) begin
            chk("R2",  "count",    count_o, m_cnt);
            chk("R4",  "capture",  capture_o, m_cap);
            chk("R11", "ovf_flag", ovf_flag_o, m_tf);
            chk("R11", "evt_flag", evt_flag_o, m_ev);
            chk("R10", "irq",      irq_o, m_tf || (m_ev && mode_now() != 1));
            chk("R7",  "baud",     baud_pulse_o, m_bp);
            chk("R8",  "clk_out",  clk_out_o, m_clk);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic load_cnt(logic [15:0] v);
        wr_data_i = v; wr_cnt_i = 1; @(negedge clk); wr_cnt_i = 0;
    endtask
    task automatic load_cap(logic [15:0] v);
        wr_data_i = v; wr_cap_i = 1; @(negedge clk); wr_cap_i = 0;
    endtask
    task automatic clear_flags();
        clr_ovf_i = 1; clr_evt_i = 1; @(negedge clk); clr_ovf_i = 0; clr_evt_i = 0;
    endtask
    task automatic evt_fall_pulse();
        evt_pin_i = 0; tick(5); evt_pin_i = 1; tick(3);
    endtask

    initial begin
        logic [15:0] held;
        int t1;
        int pulses;
        logic last_clk;
        // R1: reset state
        tick(3);
        chk("R1", "count",    count_o, 0);
        chk("R1", "capture",  capture_o, 0);
        chk("R1", "ovf_flag", ovf_flag_o, 0);
        chk("R1", "evt_flag", evt_flag_o, 0);
        chk("R1", "irq",      irq_o, 0);
        chk("R1", "baud",     baud_pulse_o, 0);
        chk("R1", "clk_out",  clk_out_o, 0);
        rst_n = 1;
        tick(2);

        // R13: register loads
        load_cap(16'h1234);
        load_cnt(16'hFFFD);
        chk("R13", "capture load", capture_o, 16'h1234);
        chk("R13", "count load", count_o, 16'hFFFD);

        // R5: reload mode overflow
        run_i = 1;
        for (int k = 0; k < 200 && !ovf_flag_o; k++) @(negedge clk);
        chk("R5", "reloaded count", count_o, 16'h1234);
        chk("R5", "ovf flag", ovf_flag_o, 1);
        chk("R10", "irq on ovf", irq_o, 1);
        tick(20);
        chk("R11", "ovf sticky", ovf_flag_o, 1);
        clear_flags();
        chk("R11", "ovf cleared", ovf_flag_o, 0);

        // R3: stop, hold, restart on a machine-cycle strobe
        run_i = 0;
        tick(1);
        held = count_o;
        tick(40);
        chk("R3", "held while stopped", count_o, held);
        do @(negedge clk); while (m_mc != MC - 1);
        run_i = 1;
        tick(1);
        chk("R3", "first cycle idle", count_o, held);
        tick(12);
        chk("R2", "one step per machine cycle", count_o, held + 16'd1);

        // R2: counter mode on pin edges (capture mode)
        cnt_sel_i = 1; cap_mode_i = 1;
        load_cnt(16'h0010);
        for (int k = 0; k < 5; k++) begin
            cnt_pin_i = 0; tick(3); cnt_pin_i = 1; tick(3);
        end
        tick(4);
        chk("R2", "five pin edges", count_o, 16'h0015);

        // R4: capture on event edge
        evt_en_i = 1;
        evt_fall_pulse();
        chk("R4", "captured count", capture_o, 16'h0015);
        chk("R4", "evt flag set", evt_flag_o, 1);
        chk("R10", "irq on evt", irq_o, 1);
        clear_flags();
        evt_en_i = 0;
        load_cap(16'h5A5A);
        evt_fall_pulse();
        chk("R4", "disabled edge keeps capture", capture_o, 16'h5A5A);
        chk("R4", "disabled edge keeps flag", evt_flag_o, 0);

        // R13: capture event beats a same-cycle write
        evt_en_i = 1;
        evt_pin_i = 0;
        tick(2);
        wr_data_i = 16'hAAAA; wr_cap_i = 1;
        tick(1);
        wr_cap_i = 0;
        chk("R13", "capture wins over write", capture_o, 16'h0015);
        tick(3); evt_pin_i = 1; tick(3);
        clear_flags();

        // R4: wrap in capture mode
        load_cnt(16'hFFFF);
        cnt_pin_i = 0; tick(3); cnt_pin_i = 1; tick(3);
        chk("R4", "wrap to zero", count_o, 16'h0000);
        chk("R4", "ovf on wrap", ovf_flag_o, 1);
        clear_flags();

        // R6: up/down mode, downward first
        cnt_sel_i = 0; cap_mode_i = 0; updown_i = 1;
        evt_pin_i = 0; tick(4);
        load_cap(16'h0100);
        load_cnt(16'h0102);
        clear_flags();
        for (int k = 0; k < 200 && !ovf_flag_o; k++) @(negedge clk);
        chk("R6", "down wrap loads top", count_o, 16'hFFFF);
        chk("R6", "evt toggled", evt_flag_o, 1);
        clr_ovf_i = 1; tick(1); clr_ovf_i = 0;
        chk("R10", "evt masked in up/down", irq_o, 0);
        evt_pin_i = 1; tick(4);
        load_cnt(16'hFFFE);
        for (int k = 0; k < 200 && !ovf_flag_o; k++) @(negedge clk);
        chk("R6", "up wrap loads capture", count_o, 16'h0100);
        chk("R6", "evt toggled back", evt_flag_o, 0);
        clear_flags();

        // R7 / R9: baud mode
        updown_i = 0; baud_en_i = 1;
        load_cap(16'hFFF0);
        load_cnt(16'hFFF0);
        clear_flags();
        for (int k = 0; k < 100 && !baud_pulse_o; k++) @(negedge clk);
        t1 = cyc;
        tick(1);
        for (int k = 0; k < 100 && !baud_pulse_o; k++) @(negedge clk);
        chk("R9", "pulse spacing", cyc - t1, 32);
        chk("R7", "ovf untouched", ovf_flag_o, 0);
        evt_fall_pulse();
        chk("R7", "evt edge in baud", evt_flag_o, 1);
        clear_flags();

        // R8 / R12: clock output wins over baud
        clkout_en_i = 1;
        last_clk = clk_out_o;
        for (int k = 0; k < 100 && clk_out_o == last_clk; k++) @(negedge clk);
        t1 = cyc;
        last_clk = clk_out_o;
        pulses = 0;
        for (int k = 0; k < 100 && clk_out_o == last_clk; k++) begin
            @(negedge clk);
            if (baud_pulse_o) pulses++;
        end
        chk("R8", "toggle spacing", cyc - t1, 32);
        chk("R12", "no baud pulse under clock output", pulses, 0);
        chk("R8", "ovf untouched", ovf_flag_o, 0);

        // R12: capture outranks up/down
        clkout_en_i = 0; baud_en_i = 0; cap_mode_i = 1; updown_i = 1;
        clear_flags();
        evt_fall_pulse();
        chk("R12", "capture mode sets evt", evt_flag_o, 1);
        tick(5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule